// File: doc/BRIEF.md
# UART Control and Status Register Front-End

This block sits between a simple word-addressed register bus and the data path of a UART: its transmitter, its receiver and their two FIFOs. Software writes control words that the block turns into enable, character-size, mode and FIFO trigger-level pins. It pushes transmit characters into the transmit FIFO and pops received characters out of the receive FIFO. Flags from the FIFOs and the shifter come back as plain inputs, and software reads them as status bits.

Both character paths use valid/ready transfers. A write to the transmit-data offset raises `tx_push_valid` in the same cycle as the bus request, for that one cycle only. The character moves only if `tx_push_ready` is high in that cycle, and it is lost if not. The block never waits or retries, so software checks the full flag first. A read of the receive-data offset raises `rx_pop_ready` for one cycle. A character is taken only when `rx_pop_valid` is also high, and the read then returns that character with its error flags.

Clearing the reset bit in control word 2 starts a soft-reset window of fixed length. During the window the FIFO/shifter reset pin is high and the bit reads back as 0. When the window ends the bit restores itself to 1, and no other register changes.

Top module: `uart_csr_top`

## Requirements
- R1: Each bus read returns `rd_valid` high and `rd_data` one clock after the request. A read of an unmapped or misaligned address, or of the transmit-data offset 0x40, returns 0. A write to an unmapped address changes no register.
- R2: Control words at 0x80 (control 1), 0x88 (control 3), 0x8C (control 4) and 0x90 (FIFO control) store every written data bit and read it back unchanged.
- R3: Writing control word 2 (0x84) with bit 0 = 0 raises `fifo_rst` from the next cycle for exactly SRST_CYCLES (4) cycles. Bit 0 reads 0 while `fifo_rst` is high and 1 after it falls, and the other registers keep their contents. Bits 15:1 of control word 2 store the written value.
- R4: `tx_en` equals control 1 bit 0 AND control 2 bit 2, and `rx_en` equals control 1 bit 0 AND control 2 bit 1. Both are low whenever control 1 bit 0 is clear.
- R5: `word8` follows control 2 bit 5. From the FIFO control word, `tx_level` follows bits 15:10, `rx_level` follows bits 5:0 and `dte_mode` follows bit 6.
- R6: Status 2 (0x98) bit 3 reads 1 only when `tx_fifo_empty` and `tx_shift_idle` are both high. All its other bits read 0.
- R7: The test/status word (0xB4) reads transmit-FIFO-empty in bit 6, receive-FIFO-empty (`rx_pop_valid` low) in bit 5, transmit-FIFO-full (`tx_push_ready` low) in bit 4 and receive-FIFO-full in bit 3. Status 1 (0x94) reads receive-data-available in bit 9 and transmit-space-available in bit 13.
- R8: A write to 0x40 drives `tx_push_valid` high in that cycle, with `tx_push_data` equal to write data bits 7:0. The character is transferred only when `tx_push_ready` is high, and it is dropped otherwise.
- R9: A read of 0x00 drives `rx_pop_ready` high in that cycle. When `rx_pop_valid` is high, the returned word holds the character in bits 7:0, 1 in bit 15, the OR of all errors in bit 14, and overrun, framing, break and parity in bits 13, 12, 11 and 10. These come from `rx_pop_err` bits 3, 2, 1 and 0.
- R10: A read of 0x00 while `rx_pop_valid` is low returns 0, with bit 15 clear.
- R11: `tx_push_valid` and `rx_pop_ready` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | DATA_W | Read data |
| tx_push_valid | output | 1 | Transmit character offered to the transmit FIFO |
| tx_push_ready | input | 1 | Transmit FIFO can accept (not full) |
| tx_push_data | output | 8 | Transmit character |
| rx_pop_valid | input | 1 | Receive FIFO holds a character (not empty) |
| rx_pop_ready | output | 1 | Pop request to the receive FIFO |
| rx_pop_data | input | 8 | Head receive character |
| rx_pop_err | input | 4 | Head character errors {overrun, framing, break, parity} |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_idle | input | 1 | Transmit shift register empty |
| rx_fifo_full | input | 1 | Receive FIFO full |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| word8 | output | 1 | 1 = 8-bit characters |
| dte_mode | output | 1 | DTE/DCE mode select |
| tx_level | output | 6 | Transmit FIFO trigger level |
| rx_level | output | 6 | Receive FIFO trigger level |
| fifo_rst | output | 1 | Soft reset to FIFOs and shifters |

## Verification
Several results are due in the cycle of the request itself: `tx_push_valid`, `tx_push_data` and `rx_pop_ready`. The bench samples them between the falling edge on which it drives the request and the next rising edge. Read data and the control-derived pins change on the rising edge that takes the request, so the bench samples them at the following falling edge. The soft-reset pin is high for the four falling-edge samples after the write is taken and low on the fifth. The bench sets the expected read value from its register model and from the status inputs it drove before the edge.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  localparam int CHAR_W    = 8;
  localparam int ERR_W     = 4;
  localparam int LVL_W     = 6;
  localparam int NUM_PLAIN = 4;

  // byte offsets of the register words
  localparam logic [7:0] OFS_RXD  = 8'h00;
  localparam logic [7:0] OFS_TXD  = 8'h40;
  localparam logic [7:0] OFS_CTL1 = 8'h80;
  localparam logic [7:0] OFS_CTL2 = 8'h84;
  localparam logic [7:0] OFS_CTL3 = 8'h88;
  localparam logic [7:0] OFS_CTL4 = 8'h8C;
  localparam logic [7:0] OFS_FIFO = 8'h90;
  localparam logic [7:0] OFS_STA1 = 8'h94;
  localparam logic [7:0] OFS_STA2 = 8'h98;
  localparam logic [7:0] OFS_TST  = 8'hB4;

  // field positions
  localparam int B_GLOBAL_EN = 0;
  localparam int B_SRST_N    = 0;
  localparam int B_RX_EN     = 1;
  localparam int B_TX_EN     = 2;
  localparam int B_WORD8     = 5;
  localparam int B_DTE       = 6;
  localparam int B_TXLVL_LO  = 10;
  localparam int B_RXLVL_LO  = 0;
  localparam int B_TXDONE    = 3;
  localparam int B_RX_AVAIL  = 9;
  localparam int B_TX_SPACE  = 13;
  localparam int B_TS_TXE    = 6;
  localparam int B_TS_RXE    = 5;
  localparam int B_TS_TXF    = 4;
  localparam int B_TS_RXF    = 3;
  localparam int B_RD_READY  = 15;
  localparam int B_RD_ANYERR = 14;
  localparam int B_RD_ERR_LO = 10;

  // indices into the plain storage array
  localparam int PIDX_CTL1 = 0;
  localparam int PIDX_CTL3 = 1;
  localparam int PIDX_CTL4 = 2;
  localparam int PIDX_FIFO = 3;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RXD, SEL_TXD, SEL_CTL1, SEL_CTL2, SEL_CTL3,
    SEL_CTL4, SEL_FIFO, SEL_STA1, SEL_STA2, SEL_TST
  } csr_sel_e;

  function automatic csr_sel_e plain_sel(input int idx);
    case (idx)
      PIDX_CTL1: return SEL_CTL1;
      PIDX_CTL3: return SEL_CTL3;
      PIDX_CTL4: return SEL_CTL4;
      default:   return SEL_FIFO;
    endcase
  endfunction

endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          sel
);

  always_comb begin
    sel = SEL_NONE;
    if (req) begin
      if      (addr == ADDR_W'(OFS_RXD))  sel = SEL_RXD;
      else if (addr == ADDR_W'(OFS_TXD))  sel = SEL_TXD;
      else if (addr == ADDR_W'(OFS_CTL1)) sel = SEL_CTL1;
      else if (addr == ADDR_W'(OFS_CTL2)) sel = SEL_CTL2;
      else if (addr == ADDR_W'(OFS_CTL3)) sel = SEL_CTL3;
      else if (addr == ADDR_W'(OFS_CTL4)) sel = SEL_CTL4;
      else if (addr == ADDR_W'(OFS_FIFO)) sel = SEL_FIFO;
      else if (addr == ADDR_W'(OFS_STA1)) sel = SEL_STA1;
      else if (addr == ADDR_W'(OFS_STA2)) sel = SEL_STA2;
      else if (addr == ADDR_W'(OFS_TST))  sel = SEL_TST;
    end
  end

endmodule

// File: rtl/uart_csr_srst.sv
module uart_csr_srst #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (start)           remain_q <= CNT_W'(CYCLES);
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign busy = (remain_q != '0);

endmodule

// File: rtl/uart_csr_rdmux.sv
module uart_csr_rdmux
  import uart_csr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  csr_sel_e                          sel,
  input  logic [NUM_PLAIN-1:0][DATA_W-1:0]  plain,
  input  logic [DATA_W-1:0]                 ctl2_word,
  input  logic                              rx_valid,
  input  logic [CHAR_W-1:0]                 rx_char,
  input  logic [ERR_W-1:0]                  rx_err,
  input  logic                              tx_ready,
  input  logic                              tx_fifo_empty,
  input  logic                              tx_shift_idle,
  input  logic                              rx_fifo_full,
  output logic [DATA_W-1:0]                 word
);

  always_comb begin
    word = '0;
    case (sel)
      SEL_RXD: begin
        if (rx_valid) begin
          word[CHAR_W-1:0]                     = rx_char;
          word[B_RD_ERR_LO +: ERR_W]           = rx_err;
          word[B_RD_ANYERR]                    = |rx_err;
          word[B_RD_READY]                     = 1'b1;
        end
      end
      SEL_CTL1: word = plain[PIDX_CTL1];
      SEL_CTL2: word = ctl2_word;
      SEL_CTL3: word = plain[PIDX_CTL3];
      SEL_CTL4: word = plain[PIDX_CTL4];
      SEL_FIFO: word = plain[PIDX_FIFO];
      SEL_STA1: begin
        word[B_RX_AVAIL] = rx_valid;
        word[B_TX_SPACE] = tx_ready;
      end
      SEL_STA2: word[B_TXDONE] = tx_fifo_empty & tx_shift_idle;
      SEL_TST: begin
        word[B_TS_TXE] = tx_fifo_empty;
        word[B_TS_RXE] = ~rx_valid;
        word[B_TS_TXF] = ~tx_ready;
        word[B_TS_RXF] = rx_fifo_full;
      end
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/uart_csr_top.sv
module uart_csr_top
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_push_valid,
  input  logic              tx_push_ready,
  output logic [7:0]        tx_push_data,
  input  logic              rx_pop_valid,
  output logic              rx_pop_ready,
  input  logic [7:0]        rx_pop_data,
  input  logic [3:0]        rx_pop_err,
  input  logic              tx_fifo_empty,
  input  logic              tx_shift_idle,
  input  logic              rx_fifo_full,
  output logic              tx_en,
  output logic              rx_en,
  output logic              word8,
  output logic              dte_mode,
  output logic [5:0]        tx_level,
  output logic [5:0]        rx_level,
  output logic              fifo_rst
);

  csr_sel_e sel;
  logic     wr_req;
  logic     rd_req;

  assign wr_req = bus_req & bus_we;
  assign rd_req = bus_req & ~bus_we;

  uart_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req  (bus_req),
    .addr (bus_addr),
    .sel  (sel)
  );

  // plain read/write control words
  logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q;

  generate
    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              word_q <= '0;
        else if (wr_req && sel == plain_sel(g))  word_q <= bus_wdata;
      end
      assign plain_q[g] = word_q;
    end
  endgenerate

  // control word 2: stored upper bits plus the self-restoring reset bit
  logic [DATA_W-1:1] ctl2_q;
  logic              srst_start;
  logic              srst_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ctl2_q <= '0;
    else if (wr_req && sel == SEL_CTL2) ctl2_q <= bus_wdata[DATA_W-1:1];
  end

  assign srst_start = wr_req && (sel == SEL_CTL2) && !bus_wdata[B_SRST_N];

  uart_csr_srst #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_start),
    .busy  (srst_busy)
  );

  assign fifo_rst = srst_busy;

  // control pins
  logic global_en;
  assign global_en = plain_q[PIDX_CTL1][B_GLOBAL_EN];
  assign tx_en     = global_en & ctl2_q[B_TX_EN];
  assign rx_en     = global_en & ctl2_q[B_RX_EN];
  assign word8     = ctl2_q[B_WORD8];
  assign dte_mode  = plain_q[PIDX_FIFO][B_DTE];
  assign tx_level  = plain_q[PIDX_FIFO][B_TXLVL_LO +: LVL_W];
  assign rx_level  = plain_q[PIDX_FIFO][B_RXLVL_LO +: LVL_W];

  // character streams
  assign tx_push_valid = wr_req && (sel == SEL_TXD);
  assign tx_push_data  = bus_wdata[CHAR_W-1:0];
  assign rx_pop_ready  = rd_req && (sel == SEL_RXD);

  // read path
  logic [DATA_W-1:0] rd_word;

  uart_csr_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .sel           (sel),
    .plain         (plain_q),
    .ctl2_word     ({ctl2_q, ~srst_busy}),
    .rx_valid      (rx_pop_valid),
    .rx_char       (rx_pop_data),
    .rx_err        (rx_pop_err),
    .tx_ready      (tx_push_ready),
    .tx_fifo_empty (tx_fifo_empty),
    .tx_shift_idle (tx_shift_idle),
    .rx_fifo_full  (rx_fifo_full),
    .word          (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_word;
    end
  end

endmodule

// File: rtl/uart_csr_sva.sv
module uart_csr_sva #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SRST_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              tx_push_valid,
  input logic              rx_pop_valid,
  input logic              rx_pop_ready,
  input logic [7:0]        rx_pop_data,
  input logic [3:0]        rx_pop_err,
  input logic              tx_en,
  input logic              rx_en,
  input logic              fifo_rst
);

  logic srst_wr;
  logic en_off_wr;
  int   run_len;

  assign srst_wr   = bus_req && bus_we && bus_addr == ADDR_W'(8'h84) && !bus_wdata[0];
  assign en_off_wr = bus_req && bus_we && bus_addr == ADDR_W'(8'h80) && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= 0;
    else if (srst_wr)  run_len <= 0;
    else if (fifo_rst) run_len <= run_len + 1;
    else               run_len <= 0;
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> rd_valid); // R1

  AST_SRST_START: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> fifo_rst); // R3

  AST_SRST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |-> run_len < SRST_CYCLES); // R3

  AST_EN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    en_off_wr |=> (!tx_en && !rx_en)); // R4

  AST_RX_PACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_ready && rx_pop_valid) |=>
      (rd_data[15] && rd_data[7:0] == $past(rx_pop_data) &&
       rd_data[14] == |$past(rx_pop_err))); // R9

  AST_RX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_ready && !rx_pop_valid) |=> rd_data == '0); // R10

  AST_STREAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_push_valid && rx_pop_ready)); // R11

endmodule

bind uart_csr_top uart_csr_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRST_CYCLES(SRST_CYCLES)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_req       (bus_req),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .rd_valid      (rd_valid),
  .rd_data       (rd_data),
  .tx_push_valid (tx_push_valid),
  .rx_pop_valid  (rx_pop_valid),
  .rx_pop_ready  (rx_pop_ready),
  .rx_pop_data   (rx_pop_data),
  .rx_pop_err    (rx_pop_err),
  .tx_en         (tx_en),
  .rx_en         (rx_en),
  .fifo_rst      (fifo_rst)
);

// File: tb/tb_uart_csr_top.sv
module tb_uart_csr_top;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          tx_push_valid;
  logic          tx_push_ready;
  logic [7:0]    tx_push_data;
  logic          rx_pop_valid = 1'b0;
  logic          rx_pop_ready;
  logic [7:0]    rx_pop_data = '0;
  logic [3:0]    rx_pop_err = '0;
  logic          tx_fifo_empty = 1'b1;
  logic          tx_shift_idle = 1'b1;
  logic          rx_fifo_full = 1'b0;
  logic          tx_en, rx_en, word8, dte_mode, fifo_rst;
  logic [5:0]    tx_level, rx_level;

  always #10 clk = ~clk;

  uart_csr_top dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .tx_push_valid(tx_push_valid),
    .tx_push_ready(tx_push_ready), .tx_push_data(tx_push_data),
    .rx_pop_valid(rx_pop_valid), .rx_pop_ready(rx_pop_ready),
    .rx_pop_data(rx_pop_data), .rx_pop_err(rx_pop_err),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_idle(tx_shift_idle),
    .rx_fifo_full(rx_fifo_full), .tx_en(tx_en), .rx_en(rx_en),
    .word8(word8), .dte_mode(dte_mode), .tx_level(tx_level),
    .rx_level(rx_level), .fifo_rst(fifo_rst)
  );

  // transmit FIFO model, depth 4
  logic [7:0] tq [4];
  int         tcount = 0;
  logic       tclr = 1'b0;
  assign tx_push_ready = (tcount < 4);

  always @(posedge clk) begin
    if (tclr) tcount <= 0;
    else if (tx_push_valid && tx_push_ready) begin
      tq[tcount] <= tx_push_data;
      tcount     <= tcount + 1;
    end
  end

  int checks = 0;
  int errors = 0;

  // register model
  logic [DW-1:0] m_ctl1 = '0, m_ctl3 = '0, m_ctl4 = '0, m_fifo = '0;
  logic [DW-1:1] m_ctl2 = '0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    logic [DW-1:0] w = '0;
    case (a)
      8'h00: if (rx_pop_valid)
               w = {1'b1, |rx_pop_err, rx_pop_err, 2'b00, rx_pop_data};
      8'h80: w = m_ctl1;
      8'h84: w = {m_ctl2, 1'b1};
      8'h88: w = m_ctl3;
      8'h8C: w = m_ctl4;
      8'h90: w = m_fifo;
      8'h94: begin w[13] = tx_push_ready; w[9] = rx_pop_valid; end
      8'h98: w[3] = tx_fifo_empty & tx_shift_idle;
      8'hB4: begin
        w[6] = tx_fifo_empty; w[5] = ~rx_pop_valid;
        w[4] = ~tx_push_ready; w[3] = rx_fifo_full;
      end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    case (a)
      8'h00: return rx_pop_valid ? "R9" : "R10";
      8'h80, 8'h88, 8'h8C, 8'h90: return "R2";
      8'h84: return "R3";
      8'h94, 8'hB4: return "R7";
      8'h98: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    if (a == 8'h40) begin
      check("R8", "push valid", tx_push_valid, 1);
      check("R8", "push data", tx_push_data, d[7:0]);
    end
    check("R11", "stream exclusive", tx_push_valid & rx_pop_ready, 0);
    case (a)
      8'h80: m_ctl1 = d;
      8'h84: m_ctl2 = d[DW-1:1];
      8'h88: m_ctl3 = d;
      8'h8C: m_ctl4 = d;
      8'h90: m_fifo = d;
      default: ;
    endcase
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read_check(input logic [AW-1:0] a);
    logic [DW-1:0] e;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    if (a == 8'h00) check("R9", "pop ready", rx_pop_ready, 1);
    e = exp_read(a);
    @(negedge clk);
    bus_req = 1'b0;
    check("R1", "read valid", rd_valid, 1);
    check(tag_of(a), $sformatf("read %h", a), rd_data, e);
  endtask

  task automatic check_pins();
    check("R4", "tx_en", tx_en, m_ctl1[0] & m_ctl2[2]);
    check("R4", "rx_en", rx_en, m_ctl1[0] & m_ctl2[1]);
    check("R5", "word8", word8, m_ctl2[5]);
    check("R5", "dte", dte_mode, m_fifo[6]);
    check("R5", "tx_level", tx_level, m_fifo[15:10]);
    check("R5", "rx_level", rx_level, m_fifo[5:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] addrs [13];
    void'($urandom(32'h5eed));
    addrs = '{8'h00, 8'h40, 8'h80, 8'h84, 8'h88, 8'h8C, 8'h90,
              8'h94, 8'h98, 8'hB4, 8'hA4, 8'h42, 8'hFC};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    check("R3", "fifo_rst after reset", fifo_rst, 0);
    check_pins();
    bus_read_check(8'h84);

    // R2 readback and R5 pins
    bus_write(8'h90, 16'hA5C7);
    bus_write(8'h88, 16'hFFFF);
    bus_read_check(8'h90);
    bus_read_check(8'h88);
    check_pins();

    // R4 gating
    bus_write(8'h84, 16'h0027);
    check_pins();
    check("R4", "tx off without global", tx_en, 0);
    bus_write(8'h80, 16'h0001);
    check("R4", "tx on", tx_en, 1);
    check("R4", "rx on", rx_en, 1);
    bus_write(8'h80, 16'h0000);
    check("R4", "tx forced off", tx_en, 0);
    check("R4", "rx forced off", rx_en, 0);
    bus_write(8'h80, 16'h0001);

    // R3 soft reset window
    bus_write(8'h84, 16'h0026);
    for (int i = 0; i < 4; i++) begin
      check("R3", $sformatf("fifo_rst cycle %0d", i), fifo_rst, 1);
      @(negedge clk);
    end
    check("R3", "fifo_rst released", fifo_rst, 0);
    bus_write(8'h84, 16'h0026);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h84;
    @(negedge clk);
    bus_req = 1'b0;
    check("R3", "reset bit low during window", rd_data, 16'h0026);
    repeat (5) @(negedge clk);
    bus_read_check(8'h84);
    bus_read_check(8'h90);
    check_pins();

    // R8 push with back-pressure
    tclr = 1'b1; @(negedge clk); tclr = 1'b0;
    for (int i = 0; i < 6; i++) bus_write(8'h40, 16'h1230 + 16'(i));
    check("R8", "fifo count after overfill", tcount, 4);
    check("R8", "first char", tq[0], 8'h30);
    check("R8", "last kept char", tq[3], 8'h33);
    bus_read_check(8'hB4);
    tclr = 1'b1; @(negedge clk); tclr = 1'b0;

    // R9 / R10 receive data
    rx_pop_valid = 1'b1; rx_pop_data = 8'h5A; rx_pop_err = 4'b1010;
    bus_read_check(8'h00);
    rx_pop_err = 4'b0000;
    bus_read_check(8'h00);
    rx_pop_valid = 1'b0; rx_pop_data = 8'hFF;
    bus_read_check(8'h00);

    // R6 combinations
    tx_fifo_empty = 1'b1; tx_shift_idle = 1'b0; bus_read_check(8'h98);
    tx_fifo_empty = 1'b0; tx_shift_idle = 1'b1; bus_read_check(8'h98);
    tx_fifo_empty = 1'b1; tx_shift_idle = 1'b1; bus_read_check(8'h98);

    // R1 unmapped write leaves registers alone
    bus_write(8'hA4, 16'hFFFF);
    bus_write(8'h82, 16'h0000);
    bus_read_check(8'hA4);
    bus_read_check(8'h80);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = addrs[$urandom_range(0, 12)];
      d = 16'($urandom);
      rx_pop_valid  = 1'($urandom);
      rx_pop_data   = 8'($urandom);
      rx_pop_err    = 4'($urandom);
      tx_fifo_empty = 1'($urandom);
      tx_shift_idle = 1'($urandom);
      rx_fifo_full  = 1'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        tclr = 1'b1; @(negedge clk); tclr = 1'b0;
      end
      if ($urandom_range(0, 1) == 1) begin
        if (a == 8'h84 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
        bus_write(a, d);
        check_pins();
        if (a == 8'h84 && !d[0]) begin
          check("R3", "random reset start", fifo_rst, 1);
          repeat (5) @(negedge clk);
        end
      end else begin
        bus_read_check(a);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule